// File: doc/BRIEF.md
# SGRAM Bank Command Sequencer

This block sits on the controller side of a four-bank double-data-rate graphics DRAM. It takes one access request at a time. A request carries a flat word address, a read/write flag, a burst-size code and an auto-precharge flag. The block splits the address into bank, row and column fields and drives the active-low command bus (chip select, row strobe, column strobe, write enable) together with the bank and address lines. The bus is sampled by the memory on the rising clock edge. The block remembers which row is open in each bank. A request that hits the open row goes straight to the column command. A request to a closed bank is opened first. A request to a bank holding a different row closes that bank first.

Two programmable gaps are honoured: the activate-to-column gap and the precharge gap, both counted in clocks. For reads, a data-valid indication is produced. It starts exactly CAS-latency clocks after the read command, with a latency of 2 or 3, and lasts for as many clocks as the burst carries beat pairs. Configuration inputs must be held stable while the block is busy.

The controller is one state machine with eight states. IDLE accepts a request. From IDLE the path is PRE (close the bank), ACT (open the bank) or XFER (issue the column command), chosen from the open-row table. PRE leads to PRE_GAP, which leads to ACT once the precharge gap has elapsed. ACT leads to ACT_GAP, which leads to XFER once the activate gap has elapsed. XFER leads to BEATS when the burst needs more than one clock. At the end of the burst the machine goes to AP_GAP when auto-precharge was requested, and to IDLE otherwise. AP_GAP returns to IDLE after the precharge gap.

Top module: `sgram_cmd_seq`

## Requirements
- R1: The address splits as bank = addr[18:17], row = addr[16:8] and column = addr[7:0]. ACTIVE drives ba = bank and a = row. READ and WRITE drive ba = bank and a[7:0] = column.
- R2: The command encodings on {cs_n, ras_n, cas_n, we_n} are: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, NOP 0111. NOP is driven in every cycle that carries no command.
- R3: ready is high only when the block is idle. A request is taken on a rising edge where req_valid and ready are both high. The first command appears in the cycle right after that edge, and ready is low in that cycle.
- R4: For a closed bank, ACTIVE is followed by READ or WRITE exactly cfg_act_dly clocks later. Values below 2 act as 2.
- R5: A request whose bank has its row open with the same row gets READ or WRITE in the first cycle, with no ACTIVE and no PRECHARGE.
- R6: A request whose bank has a different row open first gets PRECHARGE with ba = bank and a = 0. ACTIVE follows exactly cfg_pre_dly clocks later (values below 2 act as 2), and R4 then applies.
- R7: With req_autopre set, READ or WRITE carries a[8] = 1; otherwise a[8] = 0. The bank is then treated as closed. ready returns cfg_pre_dly clocks (minimum 2) after the last burst clock.
- R8: req_burst 0, 1, 2 and 3 select 2, 4, 8 and 256 words, which take 1, 2, 4 and 128 clocks counted from the READ/WRITE cycle. Without auto-precharge, ready returns in the clock after the last burst clock.
- R9: rd_valid is high for the burst's clock count, on consecutive cycles, starting exactly 2 clocks after READ (cfg_cl3 = 0) or 3 clocks after READ (cfg_cl3 = 1). It stays low for writes.
- R10: After reset all banks are closed, ready is high, the bus carries NOP and rd_valid is low.
- R11: Each bank keeps its own open row. Opening a row in one bank does not disturb the row held open by another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_act_dly | input | 4 | Activate-to-column gap in clocks |
| cfg_pre_dly | input | 4 | Precharge gap in clocks |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Flat word address {bank, row, column} |
| req_burst | input | 2 | Burst size code |
| req_autopre | input | 1 | Close the row at burst end |
| ready | output | 1 | Idle and able to take a request |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| a | output | 9 | Row, or column plus auto-precharge bit |
| rd_valid | output | 1 | Read data expected in this cycle |

## Verification
A stale open-row entry shows up in the very next request to that bank. The first command after acceptance is then the wrong kind, for example READ where PRECHARGE was due, or an ACTIVE appears where none should. A wrong gap counter moves the cycle of ACTIVE or READ/WRITE, or the cycle where ready returns, so the first mistimed command exposes it. A wrong latency tap shifts the rd_valid window by one clock from the first read onward.

// File: rtl/sgram_seq_pkg.sv
package sgram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP   = 4'b0111,
        CMD_ACT   = 4'b0011,
        CMD_READ  = 4'b0101,
        CMD_WRITE = 4'b0100,
        CMD_PRE   = 4'b0010
    } bus_cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_PRE_GAP,
        S_ACT,
        S_ACT_GAP,
        S_XFER,
        S_BEATS,
        S_AP_GAP
    } seq_state_t;

endpackage

// File: rtl/sgram_gap_counter.sv
module sgram_gap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         near_end
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // last waiting cycle once the count reaches 2 (or below)
    assign near_end = (cnt_q <= W'(2));

    p_cnt_rests_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/sgram_open_rows.sv
module sgram_open_rows #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_set,
    input  logic              open_clr,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (upd_bank == BANK_W'(b)) begin
                if (open_set) begin
                    open_q[b] <= 1'b1;
                    row_q[b]  <= upd_row;
                end else if (open_clr) begin
                    open_q[b] <= 1'b0;
                end
            end
        end
    end

    assign look_open = open_q[look_bank];
    assign look_row  = row_q[look_bank];

    p_close_takes_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (open_clr && !open_set) |=> !open_q[$past(upd_bank)]);
    p_set_and_clear_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_set && open_clr));
endmodule

// File: rtl/sgram_rd_latency.sv
module sgram_rd_latency (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_window,
    input  logic cl3,
    output logic rd_valid
);
    localparam int MAX_CL = 3;

    logic [MAX_CL-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= {pipe_q[MAX_CL-2:0], rd_window};
    end

    assign rd_valid = cl3 ? pipe_q[MAX_CL-1] : pipe_q[MAX_CL-2];

    p_latency_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_window && !cl3) |-> ##2 rd_valid);
    p_latency_three_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_window && cl3) |-> ##3 rd_valid);
endmodule

// File: rtl/sgram_cmd_seq.sv
module sgram_cmd_seq
    import sgram_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 9,
    parameter int COL_W  = 8,
    parameter int DLY_W  = 4,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  cfg_act_dly,
    input  logic [DLY_W-1:0]  cfg_pre_dly,
    input  logic              cfg_cl3,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_burst,
    input  logic              req_autopre,
    output logic              ready,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  a,
    output logic              rd_valid
);
    localparam int CNT_W  = (COL_W > DLY_W) ? COL_W : DLY_W;
    localparam int AP_BIT = COL_W;

    function automatic logic [CNT_W-1:0] burst_clocks(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(2);
            2'd2:    return CNT_W'(4);
            default: return CNT_W'(1) << (COL_W - 1);
        endcase
    endfunction

    seq_state_t st_q, st_d;

    logic              q_wr, q_ap;
    logic [BANK_W-1:0] q_bank;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;
    logic [CNT_W-1:0]  q_clocks;

    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic              accept;

    assign in_bank = req_addr[ADDR_W-1 -: BANK_W];
    assign in_row  = req_addr[COL_W +: ROW_W];
    assign in_col  = req_addr[COL_W-1:0];
    assign ready   = (st_q == S_IDLE);
    assign accept  = ready && req_valid;

    logic              look_open;
    logic [ROW_W-1:0]  look_row;
    logic [BANK_W-1:0] look_bank;
    logic              open_set, open_clr;
    logic              cnt_load, near_end, rd_window;
    logic [CNT_W-1:0]  cnt_val;
    bus_cmd_t          cmd;
    logic [BANK_W-1:0] ba_o;
    logic [ROW_W-1:0]  a_o;

    assign look_bank = ready ? in_bank : q_bank;

    sgram_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .open_set(open_set), .open_clr(open_clr),
        .upd_bank(q_bank), .upd_row(q_row),
        .look_bank(look_bank), .look_open(look_open), .look_row(look_row)
    );

    sgram_gap_counter #(.W(CNT_W)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .load(cnt_load), .load_val(cnt_val), .near_end(near_end)
    );

    sgram_rd_latency u_lat (
        .clk(clk), .rst_n(rst_n),
        .rd_window(rd_window), .cl3(cfg_cl3), .rd_valid(rd_valid)
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_wr     <= 1'b0;
            q_ap     <= 1'b0;
            q_bank   <= '0;
            q_row    <= '0;
            q_col    <= '0;
            q_clocks <= '0;
        end else if (accept) begin
            q_wr     <= req_write;
            q_ap     <= req_autopre;
            q_bank   <= in_bank;
            q_row    <= in_row;
            q_col    <= in_col;
            q_clocks <= burst_clocks(req_burst);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= S_IDLE;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (!look_open)              st_d = S_ACT;
                    else if (look_row == in_row) st_d = S_XFER;
                    else                         st_d = S_PRE;
                end
            end
            S_PRE:     st_d = S_PRE_GAP;
            S_PRE_GAP: if (near_end) st_d = S_ACT;
            S_ACT:     st_d = S_ACT_GAP;
            S_ACT_GAP: if (near_end) st_d = S_XFER;
            S_XFER: begin
                if (q_clocks > CNT_W'(1)) st_d = S_BEATS;
                else                      st_d = q_ap ? S_AP_GAP : S_IDLE;
            end
            S_BEATS:   if (near_end) st_d = q_ap ? S_AP_GAP : S_IDLE;
            S_AP_GAP:  if (near_end) st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    // outputs and counter control
    always_comb begin
        cmd       = CMD_NOP;
        ba_o      = '0;
        a_o       = '0;
        open_set  = 1'b0;
        open_clr  = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        rd_window = 1'b0;
        unique case (st_q)
            S_PRE: begin
                cmd      = CMD_PRE;
                ba_o     = q_bank;
                open_clr = 1'b1;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(cfg_pre_dly);
            end
            S_ACT: begin
                cmd      = CMD_ACT;
                ba_o     = q_bank;
                a_o      = q_row;
                open_set = 1'b1;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(cfg_act_dly);
            end
            S_XFER: begin
                cmd                = q_wr ? CMD_WRITE : CMD_READ;
                ba_o               = q_bank;
                a_o[COL_W-1:0]     = q_col;
                a_o[AP_BIT]        = q_ap;
                open_clr           = q_ap;
                rd_window          = !q_wr;
                if (q_clocks > CNT_W'(1)) begin
                    cnt_load = 1'b1;
                    cnt_val  = q_clocks;
                end else if (q_ap) begin
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(cfg_pre_dly);
                end
            end
            S_BEATS: begin
                rd_window = !q_wr;
                if (near_end && q_ap) begin
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(cfg_pre_dly);
                end
            end
            default: ;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign ba = ba_o;
    assign a  = a_o;

    p_legal_encoding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd inside {CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE, CMD_PRE});
    p_accept_issues_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cmd != CMD_NOP && !ready));
    p_act_gap_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |=> (cmd == CMD_NOP));
    p_column_needs_open_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ || cmd == CMD_WRITE) |-> (look_open && look_row == q_row));
    p_pre_gap_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |=> (cmd == CMD_NOP));
    p_pre_single_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (a[AP_BIT] == 1'b0));
endmodule

// File: tb/test_sgram_cmd_seq.sv
module test_sgram_cmd_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_act_dly = 4'd2, cfg_pre_dly = 4'd2;
    logic       cfg_cl3 = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [18:0] req_addr = '0;
    logic [1:0] req_burst = 2'd0;
    logic       ready, cs_n, ras_n, cas_n, we_n, rd_valid;
    logic [1:0] ba;
    logic [8:0] a;

    always #2.5 clk = ~clk;

    sgram_cmd_seq i_sgram_cmd_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_act_dly(cfg_act_dly), .cfg_pre_dly(cfg_pre_dly), .cfg_cl3(cfg_cl3),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_burst(req_burst), .req_autopre(req_autopre),
        .ready(ready), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a(a), .rd_valid(rd_valid)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit m_open [4];
    int m_row  [4];
    int last_act;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int eff(input int d);
        return (d < 2) ? 2 : d;
    endfunction

    task automatic run_req(input bit wr, input int bank, input int row, input int col,
                           input int burst, input bit ap);
        int path, f, pre_c, act_c, rw_c, rv_first, rv_n, rdy_c, nclk, cl, ea, ep;
        int exp_act, exp_rw, exp_rdy;
        logic [3:0] bus;
        path = !m_open[bank] ? 1 : (m_row[bank] == row ? 0 : 2); // 0 hit,1 closed,2 miss
        m_open[bank] = !ap;
        m_row[bank]  = row;
        nclk = (burst == 3) ? 128 : (1 << burst);
        cl = cfg_cl3 ? 3 : 2;
        ea = eff(int'(cfg_act_dly));
        ep = eff(int'(cfg_pre_dly));
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_burst = 2'(burst); req_autopre = ap;
        req_addr = {2'(bank), 9'(row), 8'(col)};
        @(negedge clk);
        req_valid = 1'b0;
        f = cyc;
        check(ready == 1'b0, "R3 ready low while busy", int'(ready), 0);
        pre_c = -1; act_c = -1; rw_c = -1; rv_first = -1; rv_n = 0; rdy_c = -1;
        for (int k = 0; k < 400; k++) begin
            bus = {cs_n, ras_n, cas_n, we_n};
            if (bus == 4'b0010) begin
                pre_c = cyc;
                check(ba == 2'(bank) && a == 9'd0, "R6 precharge ba/a", {ba, a}, bank << 9);
            end else if (bus == 4'b0011) begin
                act_c = cyc;
                check(ba == 2'(bank) && a == 9'(row), "R1 activate ba/a", {ba, a}, (bank << 9) | row);
            end else if (bus == 4'b0101 || bus == 4'b0100) begin
                rw_c = cyc;
                check(bus == (wr ? 4'b0100 : 4'b0101), "R2 column command code", bus, wr ? 4 : 5);
                check(ba == 2'(bank) && a == 9'((int'(ap) << 8) | col), "R7 column ba/a with auto-precharge bit",
                      {ba, a}, (bank << 9) | (int'(ap) << 8) | col);
            end else if (bus != 4'b0111) begin
                check(1'b0, "R2 illegal bus code", bus, 7);
            end
            if (rd_valid) begin
                if (rv_first < 0) rv_first = cyc;
                rv_n++;
            end
            if (ready && rdy_c < 0) rdy_c = cyc;
            if (rdy_c >= 0 && cyc >= rdy_c + 4) break;
            @(negedge clk);
        end
        exp_act = (path == 0) ? -1 : (path == 1 ? f : f + ep);
        exp_rw  = (path == 0) ? f : exp_act + ea;
        exp_rdy = ap ? exp_rw + nclk - 1 + ep : exp_rw + nclk;
        check(pre_c == (path == 2 ? f : -1), "R6 precharge cycle", pre_c, path == 2 ? f : -1);
        check(act_c == exp_act, path == 0 ? "R5 no activate on hit" : "R4 activate cycle", act_c, exp_act);
        check(rw_c == exp_rw, "R4 column command cycle", rw_c, exp_rw);
        check(rdy_c == exp_rdy, ap ? "R7 ready after auto-precharge" : "R8 ready after burst", rdy_c, exp_rdy);
        check(rv_n == (wr ? 0 : nclk), "R9 rd_valid length", rv_n, wr ? 0 : nclk);
        if (!wr) check(rv_first == exp_rw + cl, "R9 rd_valid start", rv_first, exp_rw + cl);
        last_act = act_c;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; m_row[b] = 0; end
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R10 ready after reset", int'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R10 NOP after reset",
              {cs_n, ras_n, cas_n, we_n}, 7);
        check(rd_valid == 1'b0 && ready == 1'b1, "R10 rd_valid low, ready high", {rd_valid, ready}, 1);

        // sweep: latency x burst x auto-precharge, each combo closed/hit/miss
        begin
            int it = 0;
            for (int cl = 0; cl < 2; cl++)
                for (int bu = 0; bu < 4; bu++)
                    for (int ap = 0; ap < 2; ap++) begin
                        int bank, r1;
                        bank = it % 4;
                        r1 = (it * 37 + 3) % 511;
                        cfg_cl3 = cl[0];
                        cfg_act_dly = 4'(2 + it % 4);
                        cfg_pre_dly = 4'(2 + (it + 1) % 4);
                        run_req(1'b0, bank, r1, (it * 11) % 256, bu, 1'b0);
                        run_req(it[0], bank, r1, (it * 5 + 1) % 256, bu, 1'b0);
                        run_req(!it[0], bank, r1 + 1, 255 - it, bu, ap[0]);
                        it++;
                    end
        end

        // R4/R6: gap settings below 2 act as 2
        cfg_act_dly = 4'd1; cfg_pre_dly = 4'd0; cfg_cl3 = 1'b0;
        run_req(1'b0, 2, 40, 7, 1, 1'b0);
        run_req(1'b1, 2, 41, 8, 0, 1'b0);

        // R11: banks hold rows independently
        cfg_act_dly = 4'd3; cfg_pre_dly = 4'd3;
        run_req(1'b0, 0, 10, 1, 0, 1'b0);
        run_req(1'b0, 1, 20, 2, 0, 1'b0);
        run_req(1'b0, 3, 30, 3, 1, 1'b0);
        run_req(1'b0, 0, 10, 4, 0, 1'b0);
        check(last_act < 0, "R11 bank 0 row kept while others opened", last_act, -1);
        run_req(1'b1, 1, 20, 5, 2, 1'b0);
        check(last_act < 0, "R11 bank 1 row kept", last_act, -1);

        finish_run();
    end
endmodule